// File: doc/BRIEF.md
# SDRAM Write-to-Read Spacing Enforcer

This block takes one write or read request at a time from a simple controller front end. Each request names a bank and a row. The block turns the request into a short sequence of SDRAM commands on a one-command-per-clock bus. It keeps an open-row register and a valid bit for every bank. From these it decides whether the access hits the open row, must first close another row, or must open a row in an idle bank.

A READ that follows a WRITE must not come too early. The write data burst has to finish on the pins first. The minimum WRITE-to-READ distance is half the burst length plus two clocks. When the read hits the open row of the written bank, the READ simply waits that long. When the read needs another row in the written bank, the PRECHARGE waits that long instead, and the ACTIVE and READ follow after the row-precharge and row-to-column delays. When the read goes to another bank, that bank's precharge and activate run during the write turnaround. Only the READ itself is held back. Burst length and both row delays come in as configuration inputs. They are held steady while a request is in progress.

Top module: `wr_spacer`

## Requirements
- R1: After reset, the command output carries NOP (code 0) with bank 0 and row 0, and `reqReady` is high.
- R2: A READ never appears sooner than tWRD cycles after the most recent WRITE. tWRD is 3, 4 or 6 for `cfgBurst` 0 (burst 2), 1 (burst 4), or 2 and 3 (burst 8). A read that hits the open row of its bank issues READ, with no PRECHARGE or ACTIVE, at the later of acceptance cycle + 2 and last WRITE + tWRD.
- R3: A request to a bank whose open row differs first issues PRECHARGE to that bank. The PRECHARGE comes at the later of acceptance cycle + 2 and that bank's last WRITE + tWRD.
- R4: ACTIVE, carrying the requested row, appears exactly `cfgTrp` cycles after the PRECHARGE of the same request.
- R5: The READ or WRITE of a request that opened a row appears `cfgTrcd` cycles after its ACTIVE. For a READ, the time is pushed later if R2 demands it.
- R6: A request to a bank with no open row issues ACTIVE at acceptance cycle + 2, with no PRECHARGE. A WRITE that hits the open row issues at acceptance cycle + 2.
- R7: For a read to a bank other than the last written one, PRECHARGE and ACTIVE do not wait for the write turnaround. Only the READ is held to last WRITE + tWRD.
- R8: `reqReady` is high only when no request is in progress. It is low from the cycle after acceptance until the cycle in which that request's last command appears. The acceptance cycle is the cycle at whose closing clock edge `reqValid` and `reqReady` are both high.
- R9: The command codes are NOP 0, ACTIVE 1, READ 2, WRITE 3 and PRECHARGE 4. Every cycle without a due command carries NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted at this edge if valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBank | input | BANK_W | Target bank |
| reqRow | input | ROW_W | Target row |
| cfgBurst | input | 2 | Burst length select (0: 2, 1: 4, 2/3: 8) |
| cfgTrp | input | 3 | PRECHARGE-to-ACTIVE cycles, 1 to 7 |
| cfgTrcd | input | 3 | ACTIVE-to-READ/WRITE cycles, 1 to 7 |
| cmdCode | output | 3 | Command code of this cycle |
| cmdBank | output | BANK_W | Bank of the command |
| cmdRow | output | ROW_W | Row carried with the command |

## Verification
On every cycle the assertions check minimum distances on the command bus itself. They cover WRITE to READ, WRITE to PRECHARGE of the written bank, PRECHARGE to ACTIVE, and ACTIVE to column command, each measured by free-running counters of elapsed cycles. Other behaviours can only be shown by the bench's scenarios. These are the choice among the hit, miss and idle-bank sequences, and the exact issue cycle of each command. They also include prep on another bank overlapping the write turnaround, with the READ still held until the turnaround ends, and the change of turnaround with burst length.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef struct packed {
    logic capture;  // latch the incoming request
    logic fire;     // put a command on the bus next cycle
    cmd_e kind;     // which command
  } strobe_t;

  // write-to-read turnaround: half the burst plus two
  function automatic logic [3:0] turnGap(input logic [1:0] burstSel);
    case (burstSel)
      2'd0:    turnGap = 4'd3;
      2'd1:    turnGap = 4'd4;
      default: turnGap = 4'd6;
    endcase
  endfunction

  // row delay as used by the wait counters (0 behaves as 1)
  function automatic logic [2:0] waitLoad(input logic [2:0] cfg);
    waitLoad = (cfg == 3'd0) ? 3'd0 : cfg - 3'd1;
  endfunction

endpackage

// File: rtl/wrs_ctrl.sv
module wrs_ctrl
  import wrs_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ROW_W = 13,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqBank_unused_guard,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [1:0]        cfgBurst,
  input  logic [2:0]        cfgTrp,
  input  logic [2:0]        cfgTrcd,
  input  logic [BANK_W-1:0] heldBank,
  input  logic [ROW_W-1:0]  heldRow,
  input  logic              heldWrite,
  output strobe_t           strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_ACT, ST_ISSUE} state_e;

  state_e             state, nextState;
  logic [3:0]         rdWait;              // global write-to-read wait
  logic [2:0]         stepWait;            // tRP / tRCD wait
  logic [3:0]         bankWait  [BANKS];   // per-bank write-to-precharge wait
  logic               openValid [BANKS];
  logic [ROW_W-1:0]   openRow   [BANKS];
  logic [3:0]         gapLoad;

  assign gapLoad  = turnGap(cfgBurst) - 4'd1;
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strobe    = '{capture: 1'b0, fire: 1'b0, kind: CMD_NOP};
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          if (openValid[reqBank] && (openRow[reqBank] == reqRow)) nextState = ST_ISSUE;
          else if (openValid[reqBank])                           nextState = ST_PRE;
          else                                                   nextState = ST_ACT;
        end
      end
      ST_PRE: begin
        if (bankWait[heldBank] == 4'd0) begin
          strobe.fire = 1'b1;
          strobe.kind = CMD_PRE;
          nextState   = ST_ACT;
        end
      end
      ST_ACT: begin
        if (stepWait == 3'd0) begin
          strobe.fire = 1'b1;
          strobe.kind = CMD_ACT;
          nextState   = ST_ISSUE;
        end
      end
      default: begin
        if ((stepWait == 3'd0) && (heldWrite || (rdWait == 4'd0))) begin
          strobe.fire = 1'b1;
          strobe.kind = heldWrite ? CMD_WR : CMD_RD;
          nextState   = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rdWait   <= 4'd0;
      stepWait <= 3'd0;
    end else begin
      state <= nextState;
      if (strobe.fire && strobe.kind == CMD_WR) rdWait <= gapLoad;
      else if (rdWait != 4'd0)                  rdWait <= rdWait - 4'd1;
      if (strobe.fire && strobe.kind == CMD_PRE)      stepWait <= waitLoad(cfgTrp);
      else if (strobe.fire && strobe.kind == CMD_ACT) stepWait <= waitLoad(cfgTrcd);
      else if (stepWait != 3'd0)                      stepWait <= stepWait - 3'd1;
    end
  end

  for (genvar g = 0; g < BANKS; g++) begin : gBank
    logic hitMe;
    assign hitMe = strobe.fire && (heldBank == BANK_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankWait[g]  <= 4'd0;
        openValid[g] <= 1'b0;
        openRow[g]   <= '0;
      end else begin
        if (hitMe && strobe.kind == CMD_WR) bankWait[g] <= gapLoad;
        else if (bankWait[g] != 4'd0)       bankWait[g] <= bankWait[g] - 4'd1;
        if (hitMe && strobe.kind == CMD_PRE) openValid[g] <= 1'b0;
        if (hitMe && strobe.kind == CMD_ACT) begin
          openValid[g] <= 1'b1;
          openRow[g]   <= heldRow;
        end
      end
    end
  end

  logic unusedGuard;
  assign unusedGuard = reqBank_unused_guard;

endmodule

// File: rtl/wrs_dp.sv
module wrs_dp
  import wrs_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ROW_W = 13,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [1:0]        cfgBurst,
  input  logic [2:0]        cfgTrp,
  input  logic [2:0]        cfgTrcd,
  output logic [BANK_W-1:0] heldBank,
  output logic [ROW_W-1:0]  heldRow,
  output logic              heldWrite,
  output cmd_e              cmdQ,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldBank  <= '0;
      heldRow   <= '0;
      heldWrite <= 1'b0;
      cmdQ      <= CMD_NOP;
      cmdBank   <= '0;
      cmdRow    <= '0;
    end else begin
      if (strobe.capture) begin
        heldBank  <= reqBank;
        heldRow   <= reqRow;
        heldWrite <= reqWrite;
      end
      if (strobe.fire) begin
        cmdQ    <= strobe.kind;
        cmdBank <= heldBank;
        cmdRow  <= heldRow;
      end else begin
        cmdQ    <= CMD_NOP;
        cmdBank <= '0;
        cmdRow  <= '0;
      end
    end
  end

  // elapsed-cycle counters on the bus, saturating at 15
  logic [3:0]        sinceWr, sincePre, sinceAct;
  logic [BANK_W-1:0] lastWrBank;
  logic [3:0]        needWr, needRp, needRcd;

  assign needWr  = turnGap(cfgBurst);
  assign needRp  = (cfgTrp  == 3'd0) ? 4'd1 : {1'b0, cfgTrp};
  assign needRcd = (cfgTrcd == 3'd0) ? 4'd1 : {1'b0, cfgTrcd};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceWr    <= 4'd15;
      sincePre   <= 4'd15;
      sinceAct   <= 4'd15;
      lastWrBank <= '0;
    end else begin
      if (cmdQ == CMD_WR) begin
        sinceWr    <= 4'd1;
        lastWrBank <= cmdBank;
      end else if (sinceWr != 4'd15) sinceWr <= sinceWr + 4'd1;
      if (cmdQ == CMD_PRE)        sincePre <= 4'd1;
      else if (sincePre != 4'd15) sincePre <= sincePre + 4'd1;
      if (cmdQ == CMD_ACT)        sinceAct <= 4'd1;
      else if (sinceAct != 4'd15) sinceAct <= sinceAct + 4'd1;
    end
  end

  AST_WR_TO_RD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_RD) |-> (sinceWr >= needWr)); // R2
  AST_WR_TO_PRE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_PRE && cmdBank == lastWrBank) |-> (sinceWr >= needWr)); // R3
  AST_PRE_TO_ACT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_ACT) |-> (sincePre >= needRp)); // R4
  AST_ACT_TO_COL: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_RD || cmdQ == CMD_WR) |-> (sinceAct >= needRcd)); // R5

endmodule

// File: rtl/wr_spacer.sv
module wr_spacer
  import wrs_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ROW_W = 13,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [1:0]        cfgBurst,
  input  logic [2:0]        cfgTrp,
  input  logic [2:0]        cfgTrcd,
  output logic [2:0]        cmdCode,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow
);

  strobe_t           strobe;
  logic [BANK_W-1:0] heldBank;
  logic [ROW_W-1:0]  heldRow;
  logic              heldWrite;
  cmd_e              cmdQ;

  wrs_ctrl #(.BANKS(BANKS), .ROW_W(ROW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqBank_unused_guard(1'b0),
    .reqBank(reqBank), .reqRow(reqRow), .cfgBurst(cfgBurst),
    .cfgTrp(cfgTrp), .cfgTrcd(cfgTrcd), .heldBank(heldBank),
    .heldRow(heldRow), .heldWrite(heldWrite), .strobe(strobe)
  );

  wrs_dp #(.BANKS(BANKS), .ROW_W(ROW_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqBank(reqBank), .reqRow(reqRow), .cfgBurst(cfgBurst),
    .cfgTrp(cfgTrp), .cfgTrcd(cfgTrcd), .heldBank(heldBank),
    .heldRow(heldRow), .heldWrite(heldWrite), .cmdQ(cmdQ),
    .cmdBank(cmdBank), .cmdRow(cmdRow)
  );

  assign cmdCode = cmdQ;

endmodule

// File: tb/wr_spacer_bench.sv
`timescale 1ns/1ps
module wr_spacer_bench;

  localparam int BANKS = 4;
  localparam int ROW_W = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic reqReady;
  logic [1:0] reqBank = '0;
  logic [ROW_W-1:0] reqRow = '0;
  logic [1:0] cfgBurst = 2'd1;
  logic [2:0] cfgTrp = 3'd2, cfgTrcd = 3'd3;
  logic [2:0] cmdCode;
  logic [1:0] cmdBank;
  logic [ROW_W-1:0] cmdRow;

  always #4 clk = ~clk;

  wr_spacer #(.BANKS(BANKS), .ROW_W(ROW_W)) u_wr_spacer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBank(reqBank), .reqRow(reqRow),
    .cfgBurst(cfgBurst), .cfgTrp(cfgTrp), .cfgTrcd(cfgTrcd),
    .cmdCode(cmdCode), .cmdBank(cmdBank), .cmdRow(cmdRow)
  );

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard
  int    qCyc[$];
  int    qCmd[$];
  int    qBank[$];
  int    qRow[$];
  string qTag[$];

  // bench model of the requirements
  int twrd, trp, trcd;
  int lastWr = -100;
  int lastWrB [BANKS];
  bit bOpen   [BANKS];
  int bRow    [BANKS];

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int gapOf(input logic [1:0] sel);
    return (sel == 2'd0) ? 3 : (sel == 2'd1) ? 4 : 6;
  endfunction

  task automatic push(input int c, input int k, input int b, input int r, input string t);
    qCyc.push_back(c); qCmd.push_back(k); qBank.push_back(b);
    qRow.push_back(r); qTag.push_back(t);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input bit w, input int b, input int r, input string tag);
    int a, pre, act, rw;
    reqValid = 1'b1; reqWrite = w; reqBank = b[1:0]; reqRow = r[ROW_W-1:0];
    while (!reqReady) @(negedge clk);
    a = cyc;
    twrd = gapOf(cfgBurst); trp = int'(cfgTrp); trcd = int'(cfgTrcd);
    if (bOpen[b] && bRow[b] == r) begin
      rw = a + 2;
    end else if (bOpen[b]) begin
      pre = maxi(a + 2, lastWrB[b] + twrd);
      push(pre, 4, b, 0, "R3");
      act = pre + trp;
      push(act, 1, b, r, "R4");
      rw = act + trcd;
    end else begin
      act = a + 2;
      push(act, 1, b, r, "R6");
      rw = act + trcd;
    end
    if (!w) rw = maxi(rw, lastWr + twrd);
    push(rw, w ? 3 : 2, b, 0, tag);
    if (w) begin lastWr = rw; lastWrB[b] = rw; end
    bOpen[b] = 1'b1; bRow[b] = r;
    @(negedge clk);
    check(reqReady == 1'b0, "R8 ready after accept", int'(reqReady), 0);
    reqValid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (qCyc.size() != 0 && qCyc[0] < cyc) begin
        check(1'b0, {qTag[0], " missing command"}, int'(cmdCode), qCmd[0]);
        void'(qCyc.pop_front()); void'(qCmd.pop_front()); void'(qBank.pop_front());
        void'(qRow.pop_front()); void'(qTag.pop_front());
      end
      if (cmdCode != 3'd0) begin
        if (qCyc.size() == 0) begin
          check(1'b0, "R9 unexpected command", int'(cmdCode), 0);
        end else begin
          check(int'(cmdCode) == qCmd[0], {qTag[0], " code"}, int'(cmdCode), qCmd[0]);
          check(qCyc[0] == cyc, {qTag[0], " cycle"}, cyc, qCyc[0]);
          check(int'(cmdBank) == qBank[0], {qTag[0], " bank"}, int'(cmdBank), qBank[0]);
          if (qCmd[0] == 1)
            check(int'(cmdRow) == qRow[0], {qTag[0], " row"}, int'(cmdRow), qRow[0]);
          void'(qCyc.pop_front()); void'(qCmd.pop_front()); void'(qBank.pop_front());
          void'(qRow.pop_front()); void'(qTag.pop_front());
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < BANKS; i++) begin lastWrB[i] = -100; bOpen[i] = 0; bRow[i] = 0; end
    repeat (3) @(negedge clk);
    check(cmdCode == 3'd0, "R1 code in reset", int'(cmdCode), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(cmdCode == 3'd0, "R1 code", int'(cmdCode), 0);
    check(cmdBank == 2'd0 && cmdRow == '0, "R1 address", int'(cmdRow), 0);
    check(reqReady == 1'b1, "R1 ready", int'(reqReady), 1);

    // burst 4, tRP 2, tRCD 3
    send(1, 0, 5, "R6");   // idle bank: ACT then WRITE
    send(0, 0, 5, "R2");   // row hit read after write
    send(1, 0, 5, "R6");   // row hit write
    send(0, 0, 9, "R3");   // same bank, other row
    send(1, 1, 3, "R5");   // idle bank write
    send(0, 2, 7, "R7");   // other idle bank read
    send(1, 2, 7, "R6");
    send(0, 1, 3, "R7");   // other bank, open row hit
    repeat (12) @(negedge clk);

    // burst 8, tRP 1, tRCD 1
    cfgBurst = 2'd2; cfgTrp = 3'd1; cfgTrcd = 3'd1;
    @(negedge clk);
    send(1, 3, 1, "R5");
    send(0, 3, 1, "R2");   // burst 8 turnaround
    send(1, 0, 9, "R6");
    send(0, 0, 2, "R3");   // miss after write, minimum row delays
    send(1, 1, 3, "R6");
    send(0, 2, 8, "R7");   // prep overlaps turnaround, READ held
    repeat (12) @(negedge clk);

    // burst 2, tRP 3, tRCD 2
    cfgBurst = 2'd0; cfgTrp = 3'd3; cfgTrcd = 3'd2;
    @(negedge clk);
    send(1, 3, 1, "R6");
    send(0, 3, 1, "R2");   // burst 2 turnaround
    send(1, 3, 1, "R6");
    send(0, 3, 4, "R4");   // miss with longer precharge delay
    repeat (20) @(negedge clk);

    check(qCyc.size() == 0, "R9 all commands seen", qCyc.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule